// File: doc/BRIEF.md
# Taken-Only Micro Branch Target Buffer

This block is a small, fully associative branch target store that sits beside the fetch address generator and offers a next-fetch guess with no bubble. Every entry holds the full address of a branch that has resolved as taken, together with its target. A hit therefore always means "taken, go to this target"; a miss means "fall through". Each cycle the fetch stage presents one PC, and the registered result appears on the following cycle.

Two ports write to the store. The resolution port reports real branch outcomes from the back end. A taken outcome allocates an entry, or refreshes the entry that is already there, and a not-taken outcome removes a matching entry. The override port comes from the slower main predictor, which is always trusted over this block. If it says not-taken for a cached branch, the entry is dropped. If it gives a different target, the stored target is corrected. Free entries are filled first. When the store is full, a binary-tree pseudo-LRU picks the entry to replace.

Top module: `ubtb_top`

## Requirements
- R1: While reset is high and on the first cycle after it, pred_valid and pred_hit are 0, and every entry is empty, so any later lookup misses until an allocation is made.
- R2: A lookup presented with lk_valid=1 in cycle N gives pred_valid=1 in cycle N+1. On a hit, pred_hit=1 and pred_target is the stored target. On a miss, pred_hit=0 and pred_target=0. With lk_valid=0, pred_valid and pred_hit are 0 on the next cycle.
- R3: A resolution with rs_taken=1 for a PC not in the store allocates an entry holding that PC and rs_target.
- R4: A resolution with rs_taken=1 for a PC already stored overwrites that entry's target and does not create a second entry.
- R5: A resolution with rs_taken=0 removes a matching entry. When nothing matches it has no effect on the stored entries.
- R6: An override with ov_taken=0 for a stored PC removes that entry.
- R7: An override with ov_taken=1 for a stored PC whose target differs from ov_target replaces the stored target with ov_target.
- R8: An override for a PC that is not stored changes nothing. In particular it never allocates.
- R9: When resolution and override are both valid in one cycle, the resolution is applied and the override is dropped.
- R10: An allocation always takes the lowest-numbered empty entry while one exists, so all ENTRIES branches can be held at once without any eviction.
- R11: When every entry is full, an allocation replaces the entry chosen by a tree pseudo-LRU. Lookup hits and resolution writes mark an entry as recently used. After entries 0..63 are written in order, a lookup hit on entry 0 makes entry 32 the next victim.
- R12: A lookup and a write in the same cycle return the contents held before the write.
- R13: No two valid entries ever hold the same PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_pc | input | PC_W | Fetch PC to look up |
| rs_valid | input | 1 | Resolved branch report valid |
| rs_pc | input | PC_W | Resolved branch PC |
| rs_taken | input | 1 | Resolved direction, 1 = taken |
| rs_target | input | PC_W | Resolved target |
| ov_valid | input | 1 | Main-predictor override valid |
| ov_pc | input | PC_W | Overridden branch PC |
| ov_taken | input | 1 | Main predictor direction, 1 = taken |
| ov_target | input | PC_W | Main predictor target |
| pred_valid | output | 1 | Registered lookup result valid |
| pred_hit | output | 1 | Predicted taken |
| pred_target | output | PC_W | Predicted target, 0 on miss |

## Verification
Any corrupted entry shows up on the very next lookup of that PC, one cycle after the PC is presented, as a wrong hit, a wrong miss or a wrong target. A duplicate entry is the hardest fault to see: it only appears after the copy that was written is removed, when a stale twin still hits. The bench therefore removes entries after refreshing them. A faulty replacement order stays invisible until the store is full. The bench fills all entries, steers the pseudo-LRU with a single hit, and then probes both the expected victim and the protected entry.

// File: rtl/ubtb_pkg.sv
package ubtb_pkg;

    localparam int UBTB_ENTRIES = 64;
    localparam int UBTB_PC_W    = 32;

    typedef enum logic [1:0] {
        WR_NONE,
        WR_ALLOC,
        WR_RETARGET,
        WR_DROP
    } wr_op_e;

    typedef struct packed {
        wr_op_e               op;
        logic                 from_resolve;
        logic [UBTB_PC_W-1:0] pc;
        logic [UBTB_PC_W-1:0] target;
    } wr_cmd_t;

endpackage

// File: rtl/ubtb_match.sv
module ubtb_match #(
    parameter int ENTRIES = 64,
    parameter int PC_W    = 32
) (
    input  logic [PC_W-1:0]              probe_pc,
    input  logic [ENTRIES-1:0]           valid_vec,
    input  logic [ENTRIES-1:0][PC_W-1:0] tag_vec,
    output logic [ENTRIES-1:0]           hit_vec
);

    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign hit_vec[e] = valid_vec[e] && (tag_vec[e] == probe_pc);
    end

endmodule

// File: rtl/ubtb_plru.sv
module ubtb_plru #(
    parameter int ENTRIES = 64
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       use_a_en,
    input  logic [$clog2(ENTRIES)-1:0] use_a_idx,
    input  logic                       use_b_en,
    input  logic [$clog2(ENTRIES)-1:0] use_b_idx,
    output logic [$clog2(ENTRIES)-1:0] victim
);

    localparam int LV = $clog2(ENTRIES);
    localparam int NODES = ENTRIES - 1;

    // node k (heap numbering from 1) lives at bit k-1; 1 = victim on the right
    logic [NODES-1:0] tree_q, tree_d;

    function automatic logic [NODES-1:0] mark_used(input logic [NODES-1:0] t,
                                                   input logic [LV-1:0] leaf);
        logic [NODES-1:0] r;
        int node;
        logic dir;
        r = t;
        node = 1;
        for (int l = 0; l < LV; l++) begin
            dir = leaf[LV-1-l];
            r[node-1] = ~dir;
            node = node * 2 + (dir ? 1 : 0);
        end
        return r;
    endfunction

    always_comb begin
        tree_d = tree_q;
        if (use_a_en) tree_d = mark_used(tree_d, use_a_idx);
        if (use_b_en) tree_d = mark_used(tree_d, use_b_idx);
    end

    always_comb begin
        int node;
        logic dir;
        node = 1;
        victim = '0;
        for (int l = 0; l < LV; l++) begin
            dir = tree_q[node-1];
            victim[LV-1-l] = dir;
            node = node * 2 + (dir ? 1 : 0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) tree_q <= '0;
        else     tree_q <= tree_d;
    end

endmodule

// File: rtl/ubtb_top.sv
module ubtb_top
    import ubtb_pkg::*;
#(
    parameter int ENTRIES = UBTB_ENTRIES,
    parameter int PC_W    = UBTB_PC_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            lk_valid,
    input  logic [PC_W-1:0] lk_pc,
    input  logic            rs_valid,
    input  logic [PC_W-1:0] rs_pc,
    input  logic            rs_taken,
    input  logic [PC_W-1:0] rs_target,
    input  logic            ov_valid,
    input  logic [PC_W-1:0] ov_pc,
    input  logic            ov_taken,
    input  logic [PC_W-1:0] ov_target,
    output logic            pred_valid,
    output logic            pred_hit,
    output logic [PC_W-1:0] pred_target
);

    localparam int IDX_W  = $clog2(ENTRIES);
    localparam int PROBES = 3;
    localparam int P_LK = 0;
    localparam int P_RS = 1;
    localparam int P_OV = 2;

    logic [ENTRIES-1:0]           vld_q;
    logic [ENTRIES-1:0][PC_W-1:0] tag_q;
    logic [ENTRIES-1:0][PC_W-1:0] tgt_q;

    logic [PROBES-1:0][PC_W-1:0]    probe_pc;
    logic [PROBES-1:0][ENTRIES-1:0] probe_hit;

    assign probe_pc[P_LK] = lk_pc;
    assign probe_pc[P_RS] = rs_pc;
    assign probe_pc[P_OV] = ov_pc;

    for (genvar p = 0; p < PROBES; p++) begin : g_probe
        ubtb_match #(.ENTRIES(ENTRIES), .PC_W(PC_W)) u_match (
            .probe_pc (probe_pc[p]),
            .valid_vec(vld_q),
            .tag_vec  (tag_q),
            .hit_vec  (probe_hit[p])
        );
    end

    function automatic logic [IDX_W-1:0] encode(input logic [ENTRIES-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (v[i]) r = r | IDX_W'(i);
        return r;
    endfunction

    logic             lk_any, rs_any, ov_any;
    logic [IDX_W-1:0] lk_idx, rs_idx, ov_idx;

    assign lk_any = |probe_hit[P_LK];
    assign rs_any = |probe_hit[P_RS];
    assign ov_any = |probe_hit[P_OV];
    assign lk_idx = encode(probe_hit[P_LK]);
    assign rs_idx = encode(probe_hit[P_RS]);
    assign ov_idx = encode(probe_hit[P_OV]);

    // lowest-numbered empty entry
    logic             any_free;
    logic [IDX_W-1:0] free_idx;
    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!vld_q[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    logic [IDX_W-1:0] plru_victim;

    // write command: resolution outranks override
    wr_cmd_t          cmd;
    logic [IDX_W-1:0] cmd_idx;
    always_comb begin
        cmd.op           = WR_NONE;
        cmd.from_resolve = 1'b0;
        cmd.pc           = rs_pc;
        cmd.target       = rs_target;
        cmd_idx          = '0;
        if (rs_valid) begin
            cmd.from_resolve = 1'b1;
            if (rs_taken) begin
                if (rs_any) begin
                    cmd.op  = WR_RETARGET;
                    cmd_idx = rs_idx;
                end else begin
                    cmd.op  = WR_ALLOC;
                    cmd_idx = any_free ? free_idx : plru_victim;
                end
            end else if (rs_any) begin
                cmd.op  = WR_DROP;
                cmd_idx = rs_idx;
            end
        end else if (ov_valid && ov_any) begin
            cmd.pc     = ov_pc;
            cmd.target = ov_target;
            cmd_idx    = ov_idx;
            if (!ov_taken)
                cmd.op = WR_DROP;
            else if (tgt_q[ov_idx] != ov_target)
                cmd.op = WR_RETARGET;
        end
    end

    logic use_b;
    assign use_b = cmd.from_resolve && (cmd.op == WR_ALLOC || cmd.op == WR_RETARGET);

    ubtb_plru #(.ENTRIES(ENTRIES)) u_plru (
        .clk      (clk),
        .rst      (rst),
        .use_a_en (lk_valid && lk_any),
        .use_a_idx(lk_idx),
        .use_b_en (use_b),
        .use_b_idx(cmd_idx),
        .victim   (plru_victim)
    );

    // entry storage
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else begin
            unique case (cmd.op)
                WR_ALLOC: begin
                    vld_q[cmd_idx] <= 1'b1;
                    tag_q[cmd_idx] <= cmd.pc;
                    tgt_q[cmd_idx] <= cmd.target;
                end
                WR_RETARGET: tgt_q[cmd_idx] <= cmd.target;
                WR_DROP:     vld_q[cmd_idx] <= 1'b0;
                default: ;
            endcase
        end
    end

    // registered lookup result, built from pre-write contents
    always_ff @(posedge clk) begin
        if (rst) begin
            pred_valid  <= 1'b0;
            pred_hit    <= 1'b0;
            pred_target <= '0;
        end else begin
            pred_valid  <= lk_valid;
            pred_hit    <= lk_valid && lk_any;
            pred_target <= (lk_valid && lk_any) ? tgt_q[lk_idx] : '0;
        end
    end

endmodule

// File: rtl/ubtb_chk.sv
module ubtb_chk #(
    parameter int ENTRIES = 64,
    parameter int PC_W    = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               lk_valid,
    input logic               rs_valid,
    input logic               rs_taken,
    input logic [PC_W-1:0]    rs_pc,
    input logic               ov_valid,
    input logic               ov_taken,
    input logic [PC_W-1:0]    ov_pc,
    input logic               pred_valid,
    input logic               pred_hit,
    input logic [ENTRIES-1:0] vld_vec,
    input logic [ENTRIES-1:0] lk_hit_vec,
    input logic [ENTRIES-1:0] rs_hit_vec,
    input logic [ENTRIES-1:0] ov_hit_vec
);

    assert_reset_empty_R1: assert property (@(posedge clk)
        rst |=> (vld_vec == '0) && !pred_valid && !pred_hit);

    assert_lookup_valid_R2: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> pred_valid);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !pred_valid && !pred_hit);

    assert_alloc_present_R3: assert property (@(posedge clk) disable iff (rst)
        rs_valid && rs_taken |=> vld_vec != '0);

    assert_resolve_drop_R5: assert property (@(posedge clk) disable iff (rst)
        rs_valid && !rs_taken |=> (vld_vec & $past(rs_hit_vec)) == '0);

    assert_override_drop_R6: assert property (@(posedge clk) disable iff (rst)
        !rs_valid && ov_valid && !ov_taken |=> (vld_vec & $past(ov_hit_vec)) == '0);

    assert_resolve_wins_R9: assert property (@(posedge clk) disable iff (rst)
        rs_valid && rs_taken && ov_valid && (ov_pc == rs_pc) && (ov_hit_vec != '0)
        |=> (vld_vec & $past(ov_hit_vec)) == $past(ov_hit_vec));

    assert_unique_lk_R13: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_hit_vec));

    assert_unique_rs_R13: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rs_hit_vec));

    assert_unique_ov_R13: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ov_hit_vec));

endmodule

bind ubtb_top ubtb_chk #(.ENTRIES(ENTRIES), .PC_W(PC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .lk_valid  (lk_valid),
    .rs_valid  (rs_valid),
    .rs_taken  (rs_taken),
    .rs_pc     (rs_pc),
    .ov_valid  (ov_valid),
    .ov_taken  (ov_taken),
    .ov_pc     (ov_pc),
    .pred_valid(pred_valid),
    .pred_hit  (pred_hit),
    .vld_vec   (vld_q),
    .lk_hit_vec(probe_hit[P_LK]),
    .rs_hit_vec(probe_hit[P_RS]),
    .ov_hit_vec(probe_hit[P_OV])
);

// File: tb/ubtb_top_tb.sv
`timescale 1ns/1ps
module ubtb_top_tb;

    localparam int PC_W = 32;
    localparam int ENTRIES = 64;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            lk_valid = 1'b0;
    logic [PC_W-1:0] lk_pc = '0;
    logic            rs_valid = 1'b0;
    logic [PC_W-1:0] rs_pc = '0;
    logic            rs_taken = 1'b0;
    logic [PC_W-1:0] rs_target = '0;
    logic            ov_valid = 1'b0;
    logic [PC_W-1:0] ov_pc = '0;
    logic            ov_taken = 1'b0;
    logic [PC_W-1:0] ov_target = '0;
    logic            pred_valid;
    logic            pred_hit;
    logic [PC_W-1:0] pred_target;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ubtb_top #(.ENTRIES(ENTRIES), .PC_W(PC_W)) u_dut (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_pc(lk_pc),
        .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken), .rs_target(rs_target),
        .ov_valid(ov_valid), .ov_pc(ov_pc), .ov_taken(ov_taken), .ov_target(ov_target),
        .pred_valid(pred_valid), .pred_hit(pred_hit), .pred_target(pred_target)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // one cycle of stimulus; outputs sampled at the following negedge
    task automatic drive(input bit le, input logic [PC_W-1:0] lp,
                         input bit re, input logic [PC_W-1:0] rp, input bit rt,
                         input logic [PC_W-1:0] rg,
                         input bit oe, input logic [PC_W-1:0] op, input bit ot,
                         input logic [PC_W-1:0] og);
        lk_valid = le; lk_pc = lp;
        rs_valid = re; rs_pc = rp; rs_taken = rt; rs_target = rg;
        ov_valid = oe; ov_pc = op; ov_taken = ot; ov_target = og;
        @(negedge clk);
        lk_valid = 1'b0; rs_valid = 1'b0; ov_valid = 1'b0;
    endtask

    task automatic resolve(input logic [PC_W-1:0] pc, input bit tk, input logic [PC_W-1:0] tg);
        drive(0, '0, 1, pc, tk, tg, 0, '0, 0, '0);
    endtask

    task automatic override(input logic [PC_W-1:0] pc, input bit tk, input logic [PC_W-1:0] tg);
        drive(0, '0, 0, '0, 0, '0, 1, pc, tk, tg);
    endtask

    task automatic expect_lookup(input logic [PC_W-1:0] pc, input bit hit,
                                 input logic [PC_W-1:0] tg, input string req);
        drive(1, pc, 0, '0, 0, '0, 0, '0, 0, '0);
        check(pred_valid == 1'b1, req, "pred_valid", PC_W'(pred_valid), PC_W'(1));
        check(pred_hit == hit, req, "pred_hit", PC_W'(pred_hit), PC_W'(hit));
        check(pred_target == (hit ? tg : '0), req, "pred_target", pred_target, hit ? tg : '0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        @(negedge clk);
        check(!pred_valid && !pred_hit, "R1", "outputs in reset",
              PC_W'({pred_valid, pred_hit}), '0);
        rst = 1'b0;
        @(negedge clk);
        check(!pred_valid && !pred_hit, "R1", "outputs after reset",
              PC_W'({pred_valid, pred_hit}), '0);
        expect_lookup(32'h0000_1000, 0, '0, "R1");
        @(negedge clk);
        check(!pred_valid && !pred_hit, "R2", "idle after lookup",
              PC_W'({pred_valid, pred_hit}), '0);
    endtask

    task automatic t_alloc_update();
        do_reset();
        resolve(32'h0000_2000, 1, 32'h0000_A000);
        expect_lookup(32'h0000_2000, 1, 32'h0000_A000, "R3");
        expect_lookup(32'h0000_2004, 0, '0, "R2");
        resolve(32'h0000_2000, 1, 32'h0000_B000);
        expect_lookup(32'h0000_2000, 1, 32'h0000_B000, "R4");
        resolve(32'h0000_2000, 0, '0);
        expect_lookup(32'h0000_2000, 0, '0, "R4");
        resolve(32'h0000_3000, 1, 32'h0000_C000);
        resolve(32'h0000_3100, 0, '0);
        expect_lookup(32'h0000_3000, 1, 32'h0000_C000, "R5");
        resolve(32'h0000_3000, 0, '0);
        expect_lookup(32'h0000_3000, 0, '0, "R5");
    endtask

    task automatic t_override();
        do_reset();
        resolve(32'h0000_4000, 1, 32'h0000_D000);
        override(32'h0000_4000, 1, 32'h0000_D800);
        expect_lookup(32'h0000_4000, 1, 32'h0000_D800, "R7");
        override(32'h0000_4000, 0, '0);
        expect_lookup(32'h0000_4000, 0, '0, "R6");
        override(32'h0000_4400, 1, 32'h0000_E000);
        expect_lookup(32'h0000_4400, 0, '0, "R8");
    endtask

    task automatic t_conflict();
        do_reset();
        resolve(32'h0000_5000, 1, 32'h0000_F000);
        drive(0, '0, 1, 32'h0000_5000, 1, 32'h0000_F100, 1, 32'h0000_5000, 0, '0);
        expect_lookup(32'h0000_5000, 1, 32'h0000_F100, "R9");
    endtask

    task automatic t_same_cycle();
        do_reset();
        resolve(32'h0000_6000, 1, 32'h0001_0000);
        drive(1, 32'h0000_6000, 1, 32'h0000_6000, 1, 32'h0001_1000, 0, '0, 0, '0);
        check(pred_hit && pred_target == 32'h0001_0000, "R12", "old target on write",
              pred_target, 32'h0001_0000);
        expect_lookup(32'h0000_6000, 1, 32'h0001_1000, "R12");
        drive(1, 32'h0000_6100, 1, 32'h0000_6100, 1, 32'h0001_2000, 0, '0, 0, '0);
        check(!pred_hit, "R12", "miss on same-cycle alloc", PC_W'(pred_hit), '0);
        expect_lookup(32'h0000_6100, 1, 32'h0001_2000, "R12");
    endtask

    task automatic t_fill_replace();
        do_reset();
        for (int i = 0; i < ENTRIES; i++)
            resolve(32'h0010_0000 + PC_W'(i * 16), 1, 32'h0020_0000 + PC_W'(i * 4));
        for (int i = 0; i < ENTRIES; i++)
            expect_lookup(32'h0010_0000 + PC_W'(i * 16), 1, 32'h0020_0000 + PC_W'(i * 4), "R10");
        // touch entry 0, so entry 32 becomes the victim
        expect_lookup(32'h0010_0000, 1, 32'h0020_0000, "R11");
        resolve(32'h0030_0000, 1, 32'h0040_0000);
        expect_lookup(32'h0010_0000 + PC_W'(32 * 16), 0, '0, "R11");
        expect_lookup(32'h0010_0000, 1, 32'h0020_0000, "R11");
        expect_lookup(32'h0030_0000, 1, 32'h0040_0000, "R11");
        expect_lookup(32'h0010_0000 + PC_W'(33 * 16), 1, 32'h0020_0000 + PC_W'(33 * 4), "R11");
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_alloc_update();
        t_override();
        t_conflict();
        t_same_cycle();
        t_fill_replace();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule